// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets clocked logic use a 16-bit asynchronous static RAM with an 18-bit word address. Requests arrive on a valid/ready handshake that carries an address, a write flag, write data and one enable per byte lane. The block then walks the memory pins through a fixed sequence. First it presents the address and byte enables with the chip deselected. Next it selects the chip and either runs a write strobed by write enable or a read gated by output enable. Last it deselects and waits out a turnaround gap. Every phase length is a clock-cycle count. Each count is derived at elaboration from a time parameter and the clock period.

A read returns the addressed word on `rsp_rdata` together with a one-cycle `rsp_done` pulse. Bytes of lanes that were not enabled come back as zero. A write also ends with a `rsp_done` pulse. The data bus is split into a driven value, a drive enable and a sampled input. The pad logic that joins them sits outside the block.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and whenever `req_ready` is high, the memory pins are idle. Idle means `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_be_n`=all ones and `mem_dq_oe`=0. After reset `req_ready`=1 and `rsp_done`=0.
- R2: A write stores byte 7:0 only if `req_lanes[0]`=1 and byte 15:8 only if `req_lanes[1]`=1. The other byte at that address keeps its value. `mem_we_n` is low only while the chip is selected (`mem_ce1_n`=0 and `mem_ce2`=1) and the bus is driven. Data is still driven on the cycle after `mem_we_n` rises.
- R3: A write holds the chip selected with `mem_we_n` high for WSU cycles, then drives `mem_we_n` low for WPW cycles, then keeps the chip selected for WHLD cycles (2, 12 and 1 at the defaults).
- R4: A read holds `mem_oe_n` low for RD cycles (14 at the defaults) and samples `mem_dq_in` on the last of them. In `rsp_rdata`, the byte of each lane whose enable was 0 reads as zero.
- R5: `mem_dq_oe` is never high while `mem_oe_n` is low, and it is low in the cycle before `mem_oe_n` falls. Between two accesses the chip stays deselected for at least TURN+2 cycles (TURN=5 at the defaults).
- R6: `mem_addr` and `mem_be_n` are already valid one cycle before the chip is selected, and they do not change while it stays selected.
- R7: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the deselect gap ends, which is TURN cycles after `rsp_done`. `rsp_done` lasts one cycle.
- R8: Each count is the period-rounded-up ceiling of its time and is never below 1. The defaults are a 5 ns clock, a 70 ns read, 10 ns write setup, 60 ns write pulse, 70 ns write cycle and 25 ns turnaround. `rsp_done` follows acceptance after RD+1 cycles for a read and WSU+WPW+WHLD+1 cycles for a write.
- R9: A request with both lane enables 0 still runs its full sequence. A write of this kind changes no byte, and a read of this kind returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low byte enables, bit 0 = low byte |
| mem_dq_out | output | 16 | Data to drive on the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 16 | Sampled bus value |

## Verification
The hardest case to reach is a read sample taken exactly at the edge where the memory data first becomes valid. The bench memory model counts cycles with output enable low and returns filler bytes until the full read count has elapsed, so a capture even one cycle early shows up as wrong data. The second hard case is bus contention right after a read turns into a write. Randomly mixed reads and writes, often back to back on a small pool of addresses, keep producing those turnarounds. Directed cases cover single-lane writes, zero-lane requests and the top address.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RD,
        ST_WSU,
        ST_WPW,
        ST_WHLD,
        ST_TURN
    } ctrl_state_e;

    // Ceiling of a time over the clock period, never below one cycle.
    function automatic int unsigned wait_cycles(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction
endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // A phase loaded with N lasts N cycles; this flags its final cycle.
    assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/sram_lane_slice.sv
module sram_lane_slice #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              lane_en,
    input  logic [LANE_W-1:0] wr_byte,
    input  logic              busy,
    input  logic              capture,
    input  logic [LANE_W-1:0] rd_pin,
    output logic              be_n,
    output logic [LANE_W-1:0] dq_byte,
    output logic [LANE_W-1:0] rd_byte
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic              en;
        logic [LANE_W-1:0] wr;
        logic [LANE_W-1:0] rd;
    } lane_regs_t;

    lane_regs_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (accept) begin
            lane_d.en = lane_en;
            lane_d.wr = wr_byte;
        end
        if (capture) begin
            // A lane left disabled floats on the bus; report it as zero.
            lane_d.rd = lane_q.en ? rd_pin : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign be_n    = ~(lane_q.en & busy);
    assign dq_byte = lane_q.wr;
    assign rd_byte = lane_q.rd;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int CLK_PS    = 5000,
    parameter int T_RD_PS   = 70000,
    parameter int T_WSU_PS  = 10000,
    parameter int T_WPW_PS  = 60000,   // must cover both the strobe width and enable-to-end time
    parameter int T_WC_PS   = 70000,
    parameter int T_TURN_PS = 25000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_lanes,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce1_n,
    output logic                  mem_ce2,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [DATA_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_in
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    localparam int unsigned RD_CYC   = wait_cycles(T_RD_PS,   CLK_PS);
    localparam int unsigned WSU_CYC  = wait_cycles(T_WSU_PS,  CLK_PS);
    localparam int unsigned WPW_CYC  = wait_cycles(T_WPW_PS,  CLK_PS);
    localparam int unsigned TURN_CYC = wait_cycles(T_TURN_PS, CLK_PS);
    localparam int unsigned WR_USED  = (WSU_CYC + WPW_CYC) * CLK_PS;
    localparam int unsigned WHLD_CYC = (T_WC_PS > WR_USED) ?
                                       wait_cycles(T_WC_PS - WR_USED, CLK_PS) : 1;
    localparam int unsigned MAX_A    = (RD_CYC  > WPW_CYC)  ? RD_CYC  : WPW_CYC;
    localparam int unsigned MAX_B    = (WSU_CYC > TURN_CYC) ? WSU_CYC : TURN_CYC;
    localparam int unsigned MAX_C    = (MAX_A   > MAX_B)    ? MAX_A   : MAX_B;
    localparam int unsigned MAX_CYC  = (MAX_C   > WHLD_CYC) ? MAX_C   : WHLD_CYC;
    localparam int CNT_W             = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              done;
    } ctrl_regs_t;

    ctrl_regs_t        ctl_d, ctl_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              accept;
    logic              capture;
    logic              busy;
    logic              selected;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept      = 1'b1;
                    ctl_d.addr  = req_addr;
                    ctl_d.wr    = req_write;
                    ctl_d.state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (ctl_q.wr) begin
                    tmr_val     = CNT_W'(WSU_CYC);
                    ctl_d.state = ST_WSU;
                end else begin
                    tmr_val     = CNT_W'(RD_CYC);
                    ctl_d.state = ST_RD;
                end
            end
            ST_RD: begin
                if (tmr_last) begin
                    capture     = 1'b1;
                    ctl_d.done  = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(TURN_CYC);
                    ctl_d.state = ST_TURN;
                end
            end
            ST_WSU: begin
                if (tmr_last) begin
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(WPW_CYC);
                    ctl_d.state = ST_WPW;
                end
            end
            ST_WPW: begin
                if (tmr_last) begin
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(WHLD_CYC);
                    ctl_d.state = ST_WHLD;
                end
            end
            ST_WHLD: begin
                if (tmr_last) begin
                    ctl_d.done  = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(TURN_CYC);
                    ctl_d.state = ST_TURN;
                end
            end
            ST_TURN: begin
                if (tmr_last) ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    assign busy     = (ctl_q.state != ST_IDLE);
    assign selected = (ctl_q.state == ST_RD)  || (ctl_q.state == ST_WSU) ||
                      (ctl_q.state == ST_WPW) || (ctl_q.state == ST_WHLD);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_slice #(.LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .accept  (accept),
            .lane_en (req_lanes[g]),
            .wr_byte (req_wdata[LANE_W*g +: LANE_W]),
            .busy    (busy),
            .capture (capture),
            .rd_pin  (mem_dq_in[LANE_W*g +: LANE_W]),
            .be_n    (mem_be_n[g]),
            .dq_byte (mem_dq_out[LANE_W*g +: LANE_W]),
            .rd_byte (rsp_rdata[LANE_W*g +: LANE_W])
        );
    end

    assign req_ready = (ctl_q.state == ST_IDLE);
    assign rsp_done  = ctl_q.done;
    assign mem_addr  = ctl_q.addr;
    assign mem_ce1_n = ~selected;
    assign mem_ce2   = selected;
    assign mem_oe_n  = (ctl_q.state != ST_RD);
    assign mem_we_n  = (ctl_q.state != ST_WPW);
    assign mem_dq_oe = (ctl_q.state == ST_WSU) || (ctl_q.state == ST_WPW) ||
                       (ctl_q.state == ST_WHLD);
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W = 18,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              mem_dq_oe
);
    timeunit 1ns;
    timeprecision 100ps;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n)));

    p_strobe_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe && mem_oe_n));

    p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_release_before_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    p_hold_while_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce1_n |=> (mem_ce1_n || ($stable(mem_addr) && $stable(mem_be_n))));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
    timeunit 1ns;
    timeprecision 100ps;

    function automatic int bcyc(input int t_ps);
        int c;
        c = (t_ps + 4999) / 5000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD_N   = bcyc(70000);
    localparam int WSU_N  = bcyc(10000);
    localparam int WPW_N  = bcyc(60000);
    localparam int WHLD_N = (70000 > (WSU_N + WPW_N) * 5000) ? bcyc(70000 - (WSU_N + WPW_N) * 5000) : 1;
    localparam int TURN_N = bcyc(25000);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Device storage and the bench's own view of what it should hold.
    logic [15:0] dev_mem [int];
    logic [15:0] shadow  [int];

    function automatic logic [15:0] dflt(input int a);
        return a[15:0] ^ 16'h3C3C;
    endfunction
    function automatic logic [15:0] dev_get(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : dflt(a);
    endfunction
    function automatic logic [15:0] sh_get(input int a);
        return shadow.exists(a) ? shadow[a] : dflt(a);
    endfunction
    function automatic logic [15:0] lane_mask(input logic [15:0] w, input logic [1:0] ln);
        return {ln[1] ? w[15:8] : 8'h00, ln[0] ? w[7:0] : 8'h00};
    endfunction
    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] ln);
        return {ln[1] ? d[15:8] : old[15:8], ln[0] ? d[7:0] : old[7:0]};
    endfunction

    // Memory model and pin monitors, all on the falling edge.
    int  oe_cnt = 0, su_cnt = 0, pw_cnt = 0, hd_cnt = 0, desel_cnt = 0, oe_hi = 100;
    bit  wr_seen = 0, any_prev = 0, sel_prev = 0, we_prev = 1, oe_prev = 1, dqoe_prev = 0;
    logic [17:0] addr_prev = '0;
    logic [1:0]  be_prev = 2'b11;

    always @(negedge clk) begin
        if (rst_n) begin
            bit sel;
            logic [15:0] w;
            sel = !mem_ce1_n && mem_ce2;
            if (mem_dq_oe && sel && !mem_oe_n && mem_we_n)
                chk(0, "R5", "bus contention", 1, 0);
            // R4/R8: output-enable low time
            if (!mem_oe_n) oe_cnt++;
            else begin
                if (!oe_prev) chk(oe_cnt == RD_N, "R8", "read strobe cycles", oe_cnt, RD_N);
                oe_cnt = 0;
            end
            w = dev_get(int'(mem_addr));
            for (int l = 0; l < 2; l++) begin
                if (sel && !mem_oe_n && mem_we_n && !mem_be_n[l])
                    mem_dq_in[8*l +: 8] = (oe_cnt >= RD_N) ? w[8*l +: 8] : 8'h5A;
                else
                    mem_dq_in[8*l +: 8] = 8'hEE;
            end
            // R3: write phases
            if (sel && mem_we_n && !wr_seen) su_cnt++;
            if (!mem_we_n) begin
                if (we_prev) chk(su_cnt == WSU_N, "R3", "write setup cycles", su_cnt, WSU_N);
                pw_cnt++;
                wr_seen = 1;
            end
            if (mem_we_n && !we_prev) begin
                chk(pw_cnt == WPW_N, "R3", "write strobe cycles", pw_cnt, WPW_N);
                chk(sel && mem_dq_oe, "R2", "data held after strobe", {sel, mem_dq_oe}, 2'b11);
                for (int l = 0; l < 2; l++)
                    if (!mem_be_n[l]) w[8*l +: 8] = mem_dq_out[8*l +: 8];
                dev_mem[int'(mem_addr)] = w;
            end
            if (wr_seen && sel && mem_we_n) hd_cnt++;
            // R5/R6: select edges
            if (sel && !sel_prev) begin
                if (any_prev) chk(desel_cnt >= TURN_N + 2, "R5", "deselect gap", desel_cnt, TURN_N + 2);
                chk(mem_addr == addr_prev && mem_be_n == be_prev, "R6", "address/lanes set up before select",
                    {mem_addr, mem_be_n}, {addr_prev, be_prev});
            end
            if (!sel && sel_prev) begin
                if (wr_seen) chk(hd_cnt == WHLD_N, "R3", "write hold cycles", hd_cnt, WHLD_N);
                su_cnt = 0; pw_cnt = 0; hd_cnt = 0; wr_seen = 0;
                desel_cnt = 0; any_prev = 1;
            end
            if (!sel) desel_cnt++;
            if (mem_oe_n) oe_hi++; else oe_hi = 0;
            if (mem_dq_oe && !dqoe_prev)
                chk(oe_hi >= TURN_N, "R5", "output-enable high before drive", oe_hi, TURN_N);
            sel_prev = sel; we_prev = mem_we_n; oe_prev = mem_oe_n; dqoe_prev = mem_dq_oe;
            addr_prev = mem_addr; be_prev = mem_be_n;
        end
    end

    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] ln, input string tag);
        int n;
        logic [15:0] exp;
        exp = lane_mask(sh_get(int'(a)), ln);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
        @(negedge clk);
        req_valid = 0;
        req_wdata = $urandom; req_addr = $urandom; req_lanes = $urandom;
        chk(!req_ready, "R7", "busy after accept", req_ready, 0);
        n = 0;
        while (!rsp_done) begin @(negedge clk); n++; end
        if (wr) begin
            chk(n == WSU_N + WPW_N + WHLD_N + 1, "R8", "write latency", n, WSU_N + WPW_N + WHLD_N + 1);
            shadow[int'(a)] = merge(sh_get(int'(a)), d, ln);
        end else begin
            chk(n == RD_N + 1, "R8", "read latency", n, RD_N + 1);
            chk(rsp_rdata == exp, tag, "read data", rsp_rdata, exp);
        end
        @(negedge clk);
        chk(!rsp_done, "R7", "done single cycle", rsp_done, 0);
        n = 1;
        while (!req_ready) begin @(negedge clk); n++; end
        chk(n == TURN_N, "R7", "ready after done", n, TURN_N);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && mem_be_n == 2'b11,
            "R1", "pins idle in reset", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, mem_be_n}, 7'b1011011);
        chk(req_ready && !rsp_done, "R1", "handshake in reset", {req_ready, rsp_done}, 2'b10);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && mem_ce1_n && !mem_ce2, "R1", "idle after reset", {req_ready, mem_ce1_n, mem_ce2}, 3'b110);

        access(1, 18'h00000, 16'h1234, 2'b11, "R2");
        access(0, 18'h00000, 16'h0000, 2'b11, "R4");
        access(1, 18'h00000, 16'hABCD, 2'b01, "R2");
        access(0, 18'h00000, 16'h0000, 2'b11, "R2");
        access(1, 18'h00000, 16'h9977, 2'b10, "R2");
        access(0, 18'h00000, 16'h0000, 2'b11, "R2");
        access(0, 18'h00000, 16'h0000, 2'b01, "R4");
        access(0, 18'h00000, 16'h0000, 2'b10, "R4");
        access(1, 18'h00000, 16'hFFFF, 2'b00, "R9");
        access(0, 18'h00000, 16'h0000, 2'b00, "R9");
        access(0, 18'h00000, 16'h0000, 2'b11, "R9");
        access(1, 18'h3FFFF, 16'hC3A5, 2'b11, "R2");
        access(0, 18'h3FFFF, 16'h0000, 2'b11, "R4");
        access(0, 18'h21555, 16'h0000, 2'b11, "R4");

        for (int i = 0; i < 300; i++) begin
            logic [17:0] base, a;
            int sel_b;
            sel_b = $urandom % 3;
            base = (sel_b == 0) ? 18'h00000 : (sel_b == 1) ? 18'h3FFF0 : 18'h12340;
            a = base + 18'($urandom % 16);
            if ($urandom % 2) access(1, a, 16'($urandom), 2'($urandom), "R2");
            else              access(0, a, 16'h0000, 2'($urandom), "R4");
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule